// File: doc/BRIEF.md
# Debug Status and Action Register

This block is a 64-bit model-specific register inside a processor debug controller. Reading it returns a status word. Three of its bits are live levels taken from the core. Four are event flags that stay set until the next read. A read clears those flags, so a read has a side effect.

Writing the register stores nothing. Each of the low bits, when written as 1, fires a one-cycle action strobe toward the core or the clock controller. The strobes are unstall, debug-mode interrupt, system-management interrupt, stop-clocks and debug-stall. A write to the interrupt bit also pulses a set request for a flag in a separate interrupt status register.

After reset, the event flags take their initial value from bootstrap inputs. This load happens on the first clock edge after reset is released.

Top module: `dbg_stat_reg`

## Requirements
- R1: Read bits 63:7 are always zero. Writing 1s to bits 63:7 fires no strobe and changes no read value.
- R2: Four event inputs each set one sticky flag, which stays set until a read clears it:
  - rst_evt_i sets bit 6.
  - stopclk_evt_i sets bit 5.
  - dbg_act_evt_i sets bit 4.
  - susp_evt_i sets bit 1.
- R3: An accepted read clears the sticky flags on that clock edge. If a flag's event input is high in the read cycle, that flag stays set.
- R4: Bits 3, 2 and 0 read the live levels ctl_stall_i, cpu_stall_i and dmi_mode_i. They are sampled in the read cycle.
- R5: rdata_o shows the read value in the cycle after an accepted read (req_i=1, we_i=0, addr_i=REG_ADDR). It keeps that value until the next accepted read.
- R6: An accepted write fires each strobe for exactly one cycle, in the cycle after the write, for each of these bits written as 1:
  - bit 4 fires unstall_o.
  - bit 3 fires dmi_req_o.
  - bit 1 fires stopclk_req_o.
  - bit 0 fires dbg_stall_o.
- R7: An accepted write with bit 2 set always pulses smi_flag_set_o. It pulses smi_o only if smi_en_i is high in the write cycle.
- R8: Bits written as 0 fire nothing. No write changes the read value, including writes to bits 6 and 5.
- R9: A request to any other address fires no strobe, leaves rdata_o unchanged and clears no flag.
- R10: During reset, rdata_o and all strobes are 0. On the first clock edge after reset release, the sticky flags load from boot_stat_i, ORed with any event present in that cycle. The mapping is boot_stat_i[3] to bit 6, [2] to bit 5, [1] to bit 4 and [0] to bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_stat_i | input | 4 | Bootstrap initial value of the sticky flags {bit6,bit5,bit4,bit1} |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 64 | Write data (action bits) |
| rdata_o | output | 64 | Read data, valid the cycle after a read |
| rst_evt_i | input | 1 | Hard or soft reset event |
| stopclk_evt_i | input | 1 | Stop-clock action event |
| dbg_act_evt_i | input | 1 | Bus debug action event |
| susp_evt_i | input | 1 | CPU suspended event |
| ctl_stall_i | input | 1 | Controller is stalling the CPU |
| cpu_stall_i | input | 1 | CPU stalled for any reason |
| dmi_mode_i | input | 1 | CPU in debug-interrupt mode |
| smi_en_i | input | 1 | System-management interrupt enable |
| unstall_o | output | 1 | Unstall strobe |
| dmi_req_o | output | 1 | Debug-mode interrupt request strobe |
| smi_o | output | 1 | System-management interrupt strobe |
| smi_flag_set_o | output | 1 | Set pulse for the interrupt status flag |
| stopclk_req_o | output | 1 | Stop-selected-clocks strobe |
| dbg_stall_o | output | 1 | Debug-stall strobe |

## Verification
The bench raises an event in the same cycle as a clearing read. A design that gives the clear priority loses that event, and the following read shows 0 where 1 is expected.

It writes with interrupt enable low, and writes to a foreign address. It also writes all 1s to the reserved bits and to the status-only bits. A design that ignores the enable, decodes the address loosely or stores write data would fire a strobe or change the read value.

The bench checks the bootstrap load through the first read after reset. It checks that rdata_o holds between reads while random traffic runs. A missing load or an off-by-one read pipeline shows up as a mismatch in rdata_o.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
  localparam int REG_W    = 64;
  localparam int USED_W   = 7;
  localparam int N_STICKY = 4;

  localparam int B_DSTALL  = 0;
  localparam int B_SUSP    = 1;
  localparam int B_CPUSTL  = 2;
  localparam int B_CTLSTL  = 3;
  localparam int B_DBGACT  = 4;
  localparam int B_STOPCLK = 5;
  localparam int B_RSTEV   = 6;

  // sticky vector index order: {rst, stopclk, dbgact, susp}
  localparam int S_SUSP    = 0;
  localparam int S_DBGACT  = 1;
  localparam int S_STOPCLK = 2;
  localparam int S_RSTEV   = 3;

  typedef struct packed {
    logic unstall;
    logic dmi;
    logic smi;
    logic stopclk;
    logic dstall;
  } act_t;
endpackage

// File: rtl/dbg_stat_decode.sv
module dbg_stat_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o
);
  logic hit;
  assign hit      = req_i && (addr_i == REG_ADDR);
  assign rd_hit_o = hit && !we_i;
  assign wr_hit_o = hit && we_i;
endmodule

// File: rtl/dbg_stat_sticky.sv
module dbg_stat_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] boot_i,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= 1'b0;
      else if (load_i) q <= boot_i[i] | evt_i[i];
      else if (clr_i)  q <= evt_i[i];  // new event survives the clear
      else             q <= q | evt_i[i];
    end
    assign stat_o[i] = q;

    // R2
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> stat_o[i]);
    // R2
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o[i] && !clr_i) |=> stat_o[i]);
    // R3
    read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !evt_i[i] && !load_i) |=> !stat_o[i]);
  end
endmodule

// File: rtl/dbg_stat_strobe.sv
module dbg_stat_strobe
  import dbg_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [USED_W-1:0] wbits_i,
  input  logic              smi_en_i,
  output act_t              act_o,
  output logic              smi_flag_o
);
  act_t act_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      act_q.unstall <= wr_hit_i && wbits_i[B_DBGACT];
      act_q.dmi     <= wr_hit_i && wbits_i[B_CTLSTL];
      act_q.smi     <= wr_hit_i && wbits_i[B_CPUSTL] && smi_en_i;
      act_q.stopclk <= wr_hit_i && wbits_i[B_SUSP];
      act_q.dstall  <= wr_hit_i && wbits_i[B_DSTALL];
      flag_q        <= wr_hit_i && wbits_i[B_CPUSTL];
    end
  end

  assign act_o      = act_q;
  assign smi_flag_o = flag_q;

  // R9
  idle_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> (act_o == '0 && !smi_flag_o));
  // R7
  smi_implies_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o.smi |-> smi_flag_o);
  // R7
  smi_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !smi_en_i) |=> !act_o.smi);
  // R8
  zero_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && wbits_i[B_DBGACT:B_DSTALL] == '0) |=> (act_o == '0 && !smi_flag_o));
endmodule

// File: rtl/dbg_stat_reg.sv
module dbg_stat_reg
  import dbg_stat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(32'h0000_0040)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STICKY-1:0] boot_stat_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rst_evt_i,
  input  logic              stopclk_evt_i,
  input  logic              dbg_act_evt_i,
  input  logic              susp_evt_i,
  input  logic              ctl_stall_i,
  input  logic              cpu_stall_i,
  input  logic              dmi_mode_i,
  input  logic              smi_en_i,
  output logic              unstall_o,
  output logic              dmi_req_o,
  output logic              smi_o,
  output logic              smi_flag_set_o,
  output logic              stopclk_req_o,
  output logic              dbg_stall_o
);
  logic rd_hit, wr_hit;
  logic pend_q;
  logic [N_STICKY-1:0] evt, stat;
  logic [REG_W-1:0] rd_val, rdata_q;
  act_t act;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[REG_W-1:USED_W];

  dbg_stat_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .rd_hit_o(rd_hit), .wr_hit_o(wr_hit)
  );

  // first edge after reset release loads bootstrap flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b1;
    else         pend_q <= 1'b0;
  end

  always_comb begin
    evt            = '0;
    evt[S_SUSP]    = susp_evt_i;
    evt[S_DBGACT]  = dbg_act_evt_i;
    evt[S_STOPCLK] = stopclk_evt_i;
    evt[S_RSTEV]   = rst_evt_i;
  end

  dbg_stat_sticky #(.N(N_STICKY)) i_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(pend_q), .boot_i(boot_stat_i),
    .evt_i(evt), .clr_i(rd_hit), .stat_o(stat)
  );

  always_comb begin
    rd_val            = '0;
    rd_val[B_RSTEV]   = stat[S_RSTEV];
    rd_val[B_STOPCLK] = stat[S_STOPCLK];
    rd_val[B_DBGACT]  = stat[S_DBGACT];
    rd_val[B_CTLSTL]  = ctl_stall_i;
    rd_val[B_CPUSTL]  = cpu_stall_i;
    rd_val[B_SUSP]    = stat[S_SUSP];
    rd_val[B_DSTALL]  = dmi_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  dbg_stat_strobe i_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_hit_i(wr_hit),
    .wbits_i(wdata_i[USED_W-1:0]), .smi_en_i(smi_en_i),
    .act_o(act), .smi_flag_o(smi_flag_set_o)
  );

  assign unstall_o     = act.unstall;
  assign dmi_req_o     = act.dmi;
  assign smi_o         = act.smi;
  assign stopclk_req_o = act.stopclk;
  assign dbg_stall_o   = act.dstall;

  // R5
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> $stable(rdata_o));
  // R4
  live_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> (rdata_o[B_CTLSTL] == $past(ctl_stall_i)) && (rdata_o[B_CPUSTL] == $past(cpu_stall_i)));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:USED_W] == '0);
  // R9
  decode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_hit, wr_hit}));
endmodule

// File: tb/test_dbg_stat_reg.sv
module test_dbg_stat_reg;
  localparam logic [31:0] REG_A = 32'h0000_0040;
  localparam logic [31:0] OTH_A = 32'h0000_0044;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] boot = 4'b1010;
  logic req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [3:0] ev = '0;
  logic [2:0] lv = '0;
  logic en = 1'b0;
  logic unstall, dmi_req, smi, smi_flag, stopclk, dstall;

  int checks = 0, errors = 0;
  logic [3:0] exp_lat = '0;
  logic [63:0] exp_rd = '0;
  bit pend = 1'b1;

  always #2 clk = ~clk;

  dbg_stat_reg i_dbg_stat_reg (
    .clk_i(clk), .rst_ni(rst_ni), .boot_stat_i(boot),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rst_evt_i(ev[3]), .stopclk_evt_i(ev[2]), .dbg_act_evt_i(ev[1]), .susp_evt_i(ev[0]),
    .ctl_stall_i(lv[2]), .cpu_stall_i(lv[1]), .dmi_mode_i(lv[0]), .smi_en_i(en),
    .unstall_o(unstall), .dmi_req_o(dmi_req), .smi_o(smi), .smi_flag_set_o(smi_flag),
    .stopclk_req_o(stopclk), .dbg_stall_o(dstall)
  );

  function automatic logic [63:0] compose(input logic [3:0] l, input logic [2:0] v);
    logic [63:0] r = '0;
    r[6] = l[3]; r[5] = l[2]; r[4] = l[1]; r[1] = l[0];
    r[3] = v[2]; r[2] = v[1]; r[0] = v[0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rq, input bit wr, input logic [31:0] a, input logic [63:0] wd,
                      input logic [3:0] e, input logic [2:0] l, input bit se, input string tag);
    bit hit;
    logic [4:0] e_act;
    bit e_flag;
    req = rq; we = wr; addr = a; wdata = wd; ev = e; lv = l; en = se;
    hit = rq && (a == REG_A);
    if (hit && !wr) exp_rd = compose(exp_lat, l);
    e_act = {hit && wr && wd[4], hit && wr && wd[3], hit && wr && wd[2] && se,
             hit && wr && wd[1], hit && wr && wd[0]};
    e_flag = hit && wr && wd[2];
    if (pend) exp_lat = boot | e;
    else if (hit && !wr) exp_lat = e;
    else exp_lat = exp_lat | e;
    pend = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({"R5 rdata ", tag}, rdata, exp_rd);
    chk({"R6 strobes ", tag}, 64'({unstall, dmi_req, smi, stopclk, dstall}), 64'(e_act));
    chk({"R7 smi_flag ", tag}, 64'(smi_flag), 64'(e_flag));
    req = 1'b0; we = 1'b0; ev = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", rdata, 64'h0);
    chk("R10 reset strobes", 64'({unstall, dmi_req, smi, smi_flag, stopclk, dstall}), 64'h0);
    rst_ni = 1'b1;
    step(0, 0, REG_A, '0, 4'b0000, 3'b000, 0, "R10 boot load");
    step(1, 0, REG_A, '0, 4'b0000, 3'b000, 0, "R10 boot read");
    chk("R10 boot value", rdata, 64'h50);
    step(1, 0, REG_A, '0, 4'b0000, 3'b000, 0, "R3 cleared");
    chk("R3 cleared value", rdata, 64'h0);
    step(0, 0, REG_A, '0, 4'b0001, 3'b000, 0, "R2 susp event");
    step(1, 0, REG_A, '0, 4'b0000, 3'b000, 0, "R2 read susp");
    chk("R2 susp bit", rdata, 64'h2);
    step(1, 0, REG_A, '0, 4'b0010, 3'b000, 0, "R3 event during read");
    step(1, 0, REG_A, '0, 4'b0000, 3'b000, 0, "R3 kept event");
    chk("R3 kept bit4", rdata, 64'h10);
    step(1, 0, REG_A, '0, 4'b0000, 3'b101, 0, "R4 live levels");
    chk("R4 live value", rdata, 64'h9);
    step(0, 0, REG_A, '0, 4'b1100, 3'b000, 0, "R2 rst stopclk events");
    step(1, 1, OTH_A, '1, 4'b0000, 3'b000, 1, "R9 foreign write");
    step(1, 0, OTH_A, '0, 4'b0000, 3'b010, 0, "R9 foreign read");
    step(1, 1, REG_A, 64'h0, 4'b0000, 3'b000, 1, "R8 write zero");
    step(1, 1, REG_A, 64'h60, 4'b0000, 3'b000, 1, "R8 write status bits");
    step(1, 1, REG_A, 64'hFFFF_FFFF_FFFF_FF80, 4'b0000, 3'b000, 1, "R1 reserved write");
    step(1, 1, REG_A, 64'h7F, 4'b0000, 3'b000, 1, "R6 all actions");
    step(1, 1, REG_A, 64'h04, 4'b0000, 3'b000, 0, "R7 smi disabled");
    step(1, 0, REG_A, '0, 4'b0000, 3'b010, 0, "R1 R8 R9 read after writes");
    chk("R8 flags kept", rdata, 64'h64);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] e;
      logic [63:0] wd;
      bit rq, wr;
      logic [31:0] a;
      rq = ($urandom % 3) != 0;
      wr = $urandom % 2;
      a  = ($urandom % 5 == 0) ? OTH_A : REG_A;
      wd = {$urandom, $urandom};
      e  = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0;
      step(rq, wr, a, wd, e, 3'($urandom), $urandom % 2, "random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule